// File: doc/BRIEF.md
# Audio Sample FIFO Controller with DMA Thresholds

This block is the control and status core for a pair of audio sample FIFOs: one carries samples from the host toward a serial port (transmit), the other carries samples from the serial port toward the host (receive). It keeps both FIFO levels and turns them into status flags, interrupt conditions and DMA request lines. Each direction has two DMA lines. One is a normal request. The other is a more urgent panic level. Each line has its own level threshold.

The serial side is represented by a one-cycle tick, `sclk_tick`, that marks each serial clock period. Three control operations complete only after a set number of these ticks: FIFO clears, the sync bit readback and the release from standby. Software writes the sync bit and polls it back, which shows that the required serial periods have passed. Underrun on the transmit side and overrun on the receive side are latched as sticky error bits and cleared by writing 1.

Top module: `audfifo_ctrl`

## Requirements
- R1: After reset the status word reads 0x002A0000, which means transmit empty (bit 21), transmit has space (bit 19) and transmit needs writing (bit 17). All DMA and panic lines are low, `int_status` is 4'b0001 and `irq` is low.
- R2: The FIFOs are first-in first-out. The status word reports receive full at bit 22, transmit empty at bit 21, receive holds data at bit 20 and transmit has space at bit 19. Each flag shows the level one clock after the operation.
- R3: When enable (control bit 0) and DMA enable (bit 9) are both set, `dreq_tx` is high while the transmit level is below `thr_cfg[14:8]`, and `panic_tx` is high while it is below `thr_cfg[30:24]`. All four DMA lines are low otherwise.
- R4: Under the same enables, `dreq_rx` is high while the receive level is above `thr_cfg[6:0]`, and `panic_rx` is high while it is above `thr_cfg[22:16]`.
- R5: Two 2-bit codes, transmit at control bits 6:5 and receive at bits 8:7, select a limit L: 1 for code 0, otherwise DEPTH*code/4. Status bit 17 (transmit needs writing) is set while the transmit level is below L. Status bit 18 (receive needs reading) is set while the receive level is at or above L.
- R6: A serial pop of an empty transmit FIFO sets the transmit error bit 15. This applies only while the block is enabled, out of standby and transmit is on (bit 2). The bit stays set until 1 is written to control bit 15 or to `int_clr_data[2]`.
- R7: A serial push into a full receive FIFO, with receive on (bit 1), sets the receive error bit 16 and the sample is dropped. The bit clears when 1 is written to control bit 16 or to `int_clr_data[3]`.
- R8: Writing 1 to control bit 3 or bit 4 empties the transmit or receive FIFO at the clock edge that samples the second serial tick after the write. Before that edge the level does not change.
- R9: The value written to control bit 24 appears on status bit 24 at the edge that samples the second serial tick after the write.
- R10: Writing 1 to control bit 25 while it is 0 makes the serial side active after four serial ticks. Before then, serial pops and pushes have no effect. Bit 25 reads back as written.
- R11: `int_status` is {receive error, transmit error, receive needs reading, transmit needs writing} in bits 3..0. `irq` is high exactly when some bit is set in both `int_status` and `int_en`.
- R12: A host push into a full transmit FIFO has no effect, and so does a host pop of an empty receive FIFO. A serial pop while transmit is off (bit 2 clear) changes neither the level nor the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_tick | input | 1 | One-cycle pulse per serial clock period |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Control and status word |
| thr_cfg | input | 32 | DMA request and panic thresholds |
| int_en | input | 4 | Interrupt enables, bit layout as `int_status` |
| int_clr_we | input | 1 | Interrupt status write-1-to-clear strobe |
| int_clr_data | input | 4 | Bits to clear (bits 3 and 2 act) |
| int_status | output | 4 | Interrupt condition status |
| irq | output | 1 | Interrupt request |
| tx_push | input | 1 | Host writes a transmit sample |
| tx_push_data | input | DW | Transmit sample from the host |
| ser_tx_pop | input | 1 | Serial side takes a transmit sample |
| ser_tx_data | output | DW | Oldest transmit sample (0 when empty) |
| ser_rx_push | input | 1 | Serial side delivers a receive sample |
| ser_rx_data | input | DW | Receive sample from the serial side |
| rx_pop | input | 1 | Host reads a receive sample |
| rx_pop_data | output | DW | Oldest receive sample (0 when empty) |
| dreq_tx | output | 1 | Transmit DMA request |
| dreq_rx | output | 1 | Receive DMA request |
| panic_tx | output | 1 | Transmit DMA panic |
| panic_rx | output | 1 | Receive DMA panic |

## Verification
FIFO operations and control writes take effect at the next rising edge. The status word, DMA lines and interrupt outputs are all decoded from registers, so a result is due one edge after its stimulus. The bench drives every input on a falling edge and compares at the following falling edge. Clear, sync and standby results are due at the edge that samples the second or fourth tick after the write, so the bench pulses ticks one at a time and checks after each one, just before and just after the due edge. FIFO data is checked in a scoreboard queue: each host or serial pop is compared against the head of the queue just before the edge that consumes it.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;

  localparam int THR_W = 7;

  // Control / status word bit positions (software decodes these)
  localparam int CB_EN     = 0;
  localparam int CB_RXON   = 1;
  localparam int CB_TXON   = 2;
  localparam int CB_TXCLR  = 3;
  localparam int CB_RXCLR  = 4;
  localparam int CB_TXI_LO = 5;
  localparam int CB_RXI_LO = 7;
  localparam int CB_DMA    = 9;
  localparam int CB_TXERR  = 15;
  localparam int CB_RXERR  = 16;
  localparam int CB_TXW    = 17;
  localparam int CB_RXR    = 18;
  localparam int CB_TXD    = 19;
  localparam int CB_RXD    = 20;
  localparam int CB_TXE    = 21;
  localparam int CB_RXF    = 22;
  localparam int CB_SYNC   = 24;
  localparam int CB_STBY   = 25;

  // Threshold word field offsets
  localparam int TH_RXREQ = 0;
  localparam int TH_TXREQ = 8;
  localparam int TH_RXPAN = 16;
  localparam int TH_TXPAN = 24;

  // Interrupt bit positions
  localparam int IB_TXW   = 0;
  localparam int IB_RXR   = 1;
  localparam int IB_TXERR = 2;
  localparam int IB_RXERR = 3;

  typedef enum logic [1:0] {
    DLY_TXCLR = 2'd0,
    DLY_RXCLR = 2'd1,
    DLY_SYNC  = 2'd2,
    DLY_STBY  = 2'd3
  } dly_id_e;

  localparam int NUM_DLY = 4;

  function automatic int dly_ticks(input int id);
    if (id == int'(DLY_STBY)) return 4;
    return 2;
  endfunction

  function automatic int quarter_limit(input int code, input int depth);
    if (code == 0) return 1;
    return (depth * code) / 4;
  endfunction

endpackage

// File: rtl/audfifo_store.sv
module audfifo_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int LVLW = $clog2(DEPTH + 1),
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic            pop,
  input  logic            clr,
  output logic [DW-1:0]   pop_data,
  output logic [LVLW-1:0] level,
  output logic            empty,
  output logic            full
);

  logic [DW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVLW-1:0] lvl_q, lvl_d;
  logic            do_push, do_pop;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LVLW'(DEPTH));
  assign level   = lvl_q;
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (do_push) wptr_d = bump(wptr_q);
      if (do_pop)  rptr_d = bump(rptr_q);
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr_q] <= push_data;
  end

  assign pop_data = empty ? '0 : mem[rptr_q];

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVLW'(DEPTH));

  p_clr_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

  p_full_push_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> $stable(lvl_q));

endmodule

// File: rtl/audfifo_tick_delay.sv
module audfifo_tick_delay #(
  parameter int TICKS = 2,
  localparam int CW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic busy,
  output logic done
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);
  assign done = busy & tick & (cnt_q == CW'(1)) & ~start;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = CW'(TICKS);
    else if (busy && tick) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_start_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  p_wait_for_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !start) |=> busy);

endmodule

// File: rtl/audfifo_thresh.sv
module audfifo_thresh
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVLW = $clog2(DEPTH + 1),
  localparam int CMPW = (LVLW > THR_W) ? LVLW : THR_W
) (
  input  logic [LVLW-1:0] tx_level,
  input  logic [LVLW-1:0] rx_level,
  input  logic [31:0]     thr_cfg,
  input  logic            dma_on,
  input  logic [1:0]      tx_icode,
  input  logic [1:0]      rx_icode,
  output logic            dreq_tx,
  output logic            dreq_rx,
  output logic            panic_tx,
  output logic            panic_rx,
  output logic            tx_want,
  output logic            rx_ready
);

  logic [CMPW-1:0] txl, rxl, t_txreq, t_rxreq, t_txpan, t_rxpan;
  logic            unused_thr;

  assign txl     = CMPW'(tx_level);
  assign rxl     = CMPW'(rx_level);
  assign t_txreq = CMPW'(thr_cfg[TH_TXREQ +: THR_W]);
  assign t_rxreq = CMPW'(thr_cfg[TH_RXREQ +: THR_W]);
  assign t_txpan = CMPW'(thr_cfg[TH_TXPAN +: THR_W]);
  assign t_rxpan = CMPW'(thr_cfg[TH_RXPAN +: THR_W]);
  assign unused_thr = ^{thr_cfg[31], thr_cfg[23], thr_cfg[15], thr_cfg[7]};

  assign dreq_tx  = dma_on & (txl < t_txreq);
  assign panic_tx = dma_on & (txl < t_txpan);
  assign dreq_rx  = dma_on & (rxl > t_rxreq);
  assign panic_rx = dma_on & (rxl > t_rxpan);

  assign tx_want  = int'(tx_level) <  quarter_limit(int'(tx_icode), DEPTH);
  assign rx_ready = int'(rx_level) >= quarter_limit(int'(rx_icode), DEPTH);

endmodule

// File: rtl/audfifo_ctrl.sv
module audfifo_ctrl
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_tick,
  input  logic          ctl_we,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_rdata,
  input  logic [31:0]   thr_cfg,
  input  logic [3:0]    int_en,
  input  logic          int_clr_we,
  input  logic [3:0]    int_clr_data,
  output logic [3:0]    int_status,
  output logic          irq,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  input  logic          ser_tx_pop,
  output logic [DW-1:0] ser_tx_data,
  input  logic          ser_rx_push,
  input  logic [DW-1:0] ser_rx_data,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_pop_data,
  output logic          dreq_tx,
  output logic          dreq_rx,
  output logic          panic_tx,
  output logic          panic_rx
);

  localparam int LVLW = $clog2(DEPTH + 1);

  // Control state
  logic       en_q, en_d, rxon_q, rxon_d, txon_q, txon_d, dma_q, dma_d;
  logic [1:0] txi_q, txi_d, rxi_q, rxi_d;
  logic       sync_wr_q, sync_wr_d, sync_rd_q, sync_rd_d;
  logic       stby_q, stby_d, rdy_q, rdy_d;
  logic       txerr_q, txerr_d, rxerr_q, rxerr_d;

  // FIFO side
  logic [LVLW-1:0] tx_level, rx_level;
  logic            tx_empty, tx_full, rx_empty, rx_full;
  logic            active, tx_pop_go, rx_push_go, tx_underrun, rx_overrun;
  logic            tx_want, rx_ready;
  logic            unused_wbits;

  // Serial-clock delayed commands
  logic [NUM_DLY-1:0] dly_start, dly_busy, dly_done;

  assign dly_start[DLY_TXCLR] = ctl_we & ctl_wdata[CB_TXCLR];
  assign dly_start[DLY_RXCLR] = ctl_we & ctl_wdata[CB_RXCLR];
  assign dly_start[DLY_SYNC]  = ctl_we;
  assign dly_start[DLY_STBY]  = ctl_we & ctl_wdata[CB_STBY] & ~stby_q;

  generate
    for (genvar g = 0; g < NUM_DLY; g++) begin : g_dly
      audfifo_tick_delay #(.TICKS(dly_ticks(g))) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sclk_tick),
        .start (dly_start[g]),
        .busy  (dly_busy[g]),
        .done  (dly_done[g])
      );
    end
  endgenerate

  assign active      = en_q & rdy_q;
  assign tx_pop_go   = ser_tx_pop & active & txon_q;
  assign rx_push_go  = ser_rx_push & active & rxon_q;
  assign tx_underrun = tx_pop_go & tx_empty;
  assign rx_overrun  = rx_push_go & rx_full;

  assign unused_wbits = ^{ctl_wdata[31:26], ctl_wdata[23], ctl_wdata[22:17],
                          ctl_wdata[14:10], int_clr_data[1:0]};

  audfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_txf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (tx_push),
    .push_data (tx_push_data),
    .pop       (tx_pop_go),
    .clr       (dly_done[DLY_TXCLR]),
    .pop_data  (ser_tx_data),
    .level     (tx_level),
    .empty     (tx_empty),
    .full      (tx_full)
  );

  audfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_rxf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push_go),
    .push_data (ser_rx_data),
    .pop       (rx_pop),
    .clr       (dly_done[DLY_RXCLR]),
    .pop_data  (rx_pop_data),
    .level     (rx_level),
    .empty     (rx_empty),
    .full      (rx_full)
  );

  audfifo_thresh #(.DEPTH(DEPTH)) u_thr (
    .tx_level (tx_level),
    .rx_level (rx_level),
    .thr_cfg  (thr_cfg),
    .dma_on   (en_q & dma_q),
    .tx_icode (txi_q),
    .rx_icode (rxi_q),
    .dreq_tx  (dreq_tx),
    .dreq_rx  (dreq_rx),
    .panic_tx (panic_tx),
    .panic_rx (panic_rx),
    .tx_want  (tx_want),
    .rx_ready (rx_ready)
  );

  // Next-state logic
  always_comb begin
    en_d      = en_q;
    rxon_d    = rxon_q;
    txon_d    = txon_q;
    dma_d     = dma_q;
    txi_d     = txi_q;
    rxi_d     = rxi_q;
    sync_wr_d = sync_wr_q;
    sync_rd_d = sync_rd_q;
    stby_d    = stby_q;
    rdy_d     = rdy_q;
    txerr_d   = txerr_q;
    rxerr_d   = rxerr_q;
    if (ctl_we) begin
      en_d      = ctl_wdata[CB_EN];
      rxon_d    = ctl_wdata[CB_RXON];
      txon_d    = ctl_wdata[CB_TXON];
      dma_d     = ctl_wdata[CB_DMA];
      txi_d     = ctl_wdata[CB_TXI_LO +: 2];
      rxi_d     = ctl_wdata[CB_RXI_LO +: 2];
      sync_wr_d = ctl_wdata[CB_SYNC];
      stby_d    = ctl_wdata[CB_STBY];
      if (!ctl_wdata[CB_STBY]) rdy_d = 1'b0;
    end
    if (dly_done[DLY_STBY] && stby_d) rdy_d = 1'b1;
    if (dly_done[DLY_SYNC]) sync_rd_d = sync_wr_q;
    if ((ctl_we && ctl_wdata[CB_TXERR]) || (int_clr_we && int_clr_data[IB_TXERR]))
      txerr_d = 1'b0;
    if (tx_underrun) txerr_d = 1'b1;
    if ((ctl_we && ctl_wdata[CB_RXERR]) || (int_clr_we && int_clr_data[IB_RXERR]))
      rxerr_d = 1'b0;
    if (rx_overrun) rxerr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rxon_q    <= 1'b0;
      txon_q    <= 1'b0;
      dma_q     <= 1'b0;
      txi_q     <= 2'd0;
      rxi_q     <= 2'd0;
      sync_wr_q <= 1'b0;
      sync_rd_q <= 1'b0;
      stby_q    <= 1'b0;
      rdy_q     <= 1'b0;
      txerr_q   <= 1'b0;
      rxerr_q   <= 1'b0;
    end else begin
      en_q      <= en_d;
      rxon_q    <= rxon_d;
      txon_q    <= txon_d;
      dma_q     <= dma_d;
      txi_q     <= txi_d;
      rxi_q     <= rxi_d;
      sync_wr_q <= sync_wr_d;
      sync_rd_q <= sync_rd_d;
      stby_q    <= stby_d;
      rdy_q     <= rdy_d;
      txerr_q   <= txerr_d;
      rxerr_q   <= rxerr_d;
    end
  end

  // Status word
  always_comb begin
    ctl_rdata                      = '0;
    ctl_rdata[CB_EN]               = en_q;
    ctl_rdata[CB_RXON]             = rxon_q;
    ctl_rdata[CB_TXON]             = txon_q;
    ctl_rdata[CB_TXI_LO +: 2]      = txi_q;
    ctl_rdata[CB_RXI_LO +: 2]      = rxi_q;
    ctl_rdata[CB_DMA]              = dma_q;
    ctl_rdata[CB_TXERR]            = txerr_q;
    ctl_rdata[CB_RXERR]            = rxerr_q;
    ctl_rdata[CB_TXW]              = tx_want;
    ctl_rdata[CB_RXR]              = rx_ready;
    ctl_rdata[CB_TXD]              = ~tx_full;
    ctl_rdata[CB_RXD]              = ~rx_empty;
    ctl_rdata[CB_TXE]              = tx_empty;
    ctl_rdata[CB_RXF]              = rx_full;
    ctl_rdata[CB_SYNC]             = sync_rd_q;
    ctl_rdata[CB_STBY]             = stby_q;
  end

  always_comb begin
    int_status           = '0;
    int_status[IB_TXW]   = tx_want;
    int_status[IB_RXR]   = rx_ready;
    int_status[IB_TXERR] = txerr_q;
    int_status[IB_RXERR] = rxerr_q;
  end

  assign irq = |(int_status & int_en);

  p_underrun_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_tx_pop && en_q && rdy_q && txon_q && tx_empty) |=> txerr_q);

  p_overrun_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rx_push && en_q && rdy_q && rxon_q && rx_full) |=> (rxerr_q && rx_full));

  p_dma_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_tx || panic_tx || dreq_rx || panic_rx) |-> (en_q && dma_q));

  p_sync_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_tick |=> $stable(sync_rd_q));

  p_ready_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_tick && !rdy_q) |=> !rdy_q);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == 4'b0000) |-> !irq);

  p_tx_off_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!txon_q && !tx_push && !dly_done[DLY_TXCLR]) |=> $stable(tx_level));

  p_clr_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dly_start[DLY_TXCLR] |=> dly_busy[DLY_TXCLR]);

endmodule

// File: tb/tb_audfifo_ctrl.sv
module tb_audfifo_ctrl;

  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int DW    = 32;
  localparam logic [31:0] CFG = 32'h0200_0327; // en,rxon,txon,txi=1,rxi=2,dma,stby
  localparam logic [31:0] THR = (32'd8 << 24) | (32'd40 << 16) | (32'd16 << 8) | 32'd24;

  logic          clk, rst_n, sclk_tick, ctl_we, int_clr_we;
  logic [31:0]   ctl_wdata, ctl_rdata, thr_cfg;
  logic [3:0]    int_en, int_clr_data, int_status;
  logic          irq, tx_push, ser_tx_pop, ser_rx_push, rx_pop;
  logic [DW-1:0] tx_push_data, ser_tx_data, ser_rx_data, rx_pop_data;
  logic          dreq_tx, dreq_rx, panic_tx, panic_rx;

  audfifo_ctrl #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .thr_cfg(thr_cfg), .int_en(int_en), .int_clr_we(int_clr_we),
    .int_clr_data(int_clr_data), .int_status(int_status), .irq(irq),
    .tx_push(tx_push), .tx_push_data(tx_push_data),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
    .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
    .dreq_tx(dreq_tx), .dreq_rx(dreq_rx), .panic_tx(panic_tx), .panic_rx(panic_rx)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model of the requirements
  int   m_tx, m_rx;
  bit   m_en, m_rxon, m_txon, m_dma, m_txerr, m_rxerr, m_sync, m_stby, m_rdy;
  logic [1:0] m_txi, m_rxi;
  logic [DW-1:0] txq[$];
  logic [DW-1:0] rxq[$];
  event tx_ev, rx_ev;

  function automatic int lim(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (DEPTH * int'(c)) / 4;
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = '0;
    s[0] = m_en; s[1] = m_rxon; s[2] = m_txon;
    s[6:5] = m_txi; s[8:7] = m_rxi; s[9] = m_dma;
    s[15] = m_txerr; s[16] = m_rxerr;
    s[17] = (m_tx < lim(m_txi));
    s[18] = (m_rx >= lim(m_rxi));
    s[19] = (m_tx < DEPTH);
    s[20] = (m_rx > 0);
    s[21] = (m_tx == 0);
    s[22] = (m_rx == DEPTH);
    s[24] = m_sync; s[25] = m_stby;
    return s;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] s;
    logic [3:0]  dma, ist;
    bit          on;
    #1;
    s   = exp_status();
    on  = m_en && m_dma;
    dma = {on && (m_tx < 16), on && (m_rx > 24), on && (m_tx < 8), on && (m_rx > 40)};
    ist = {m_rxerr, m_txerr, s[18], s[17]};
    cmp(tag, "status", ctl_rdata, s);
    cmp(tag, "dma", {28'd0, dreq_tx, dreq_rx, panic_tx, panic_rx}, {28'd0, dma});
    cmp(tag, "int_status", {28'd0, int_status}, {28'd0, ist});
    cmp(tag, "irq", {31'd0, irq}, {31'd0, |(ist & int_en)});
  endtask

  // Scoreboard monitors: compare the head before the consuming edge
  always @(tx_ev) begin
    logic [DW-1:0] e;
    #1;
    if (txq.size() > 0) begin
      e = txq.pop_front();
      cmp("R2", "ser_tx_data", ser_tx_data, e);
    end
  end

  always @(rx_ev) begin
    logic [DW-1:0] e;
    #1;
    if (rxq.size() > 0) begin
      e = rxq.pop_front();
      cmp("R2", "rx_pop_data", rx_pop_data, e);
    end
  end

  // Drivers (called at a falling edge, return at the next one)
  task automatic host_tx_push(input logic [DW-1:0] d);
    tx_push = 1'b1; tx_push_data = d;
    if (m_tx < DEPTH) begin m_tx++; txq.push_back(d); end
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic ser_pop();
    ser_tx_pop = 1'b1;
    if (m_en && m_rdy && m_txon) begin
      if (m_tx > 0) begin -> tx_ev; m_tx--; end
      else m_txerr = 1;
    end
    @(negedge clk); ser_tx_pop = 1'b0;
  endtask

  task automatic ser_push(input logic [DW-1:0] d);
    ser_rx_push = 1'b1; ser_rx_data = d;
    if (m_en && m_rdy && m_rxon) begin
      if (m_rx < DEPTH) begin m_rx++; rxq.push_back(d); end
      else m_rxerr = 1;
    end
    @(negedge clk); ser_rx_push = 1'b0;
  endtask

  task automatic host_rx_pop();
    rx_pop = 1'b1;
    if (m_rx > 0) begin -> rx_ev; m_rx--; end
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic ctl_write(input logic [31:0] w);
    ctl_we = 1'b1; ctl_wdata = w;
    m_en = w[0]; m_rxon = w[1]; m_txon = w[2]; m_dma = w[9];
    m_txi = w[6:5]; m_rxi = w[8:7];
    if (w[15]) m_txerr = 0;
    if (w[16]) m_rxerr = 0;
    if (!w[25]) begin m_stby = 0; m_rdy = 0; end else m_stby = 1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic tick();
    sclk_tick = 1'b1;
    @(negedge clk); sclk_tick = 1'b0;
  endtask

  task automatic int_clear(input logic [3:0] b);
    int_clr_we = 1'b1; int_clr_data = b;
    if (b[2]) m_txerr = 0;
    if (b[3]) m_rxerr = 0;
    @(negedge clk); int_clr_we = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sclk_tick = 0; ctl_we = 0; ctl_wdata = '0; thr_cfg = THR;
    int_en = 4'b0000; int_clr_we = 0; int_clr_data = '0;
    tx_push = 0; tx_push_data = '0; ser_tx_pop = 0; ser_rx_push = 0;
    ser_rx_data = '0; rx_pop = 0;
    m_tx = 0; m_rx = 0; m_en = 0; m_rxon = 0; m_txon = 0; m_dma = 0;
    m_txerr = 0; m_rxerr = 0; m_sync = 0; m_stby = 0; m_rdy = 0;
    m_txi = 0; m_rxi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // Standby release (R10)
    for (int i = 0; i < 3; i++) host_tx_push(32'hA000_0000 + i);
    check_all("R2");
    ctl_write(CFG);
    check_all("R10");
    repeat (3) tick();
    ser_pop();               // inactive: ignored
    check_all("R10");
    tick(); m_rdy = 1;
    ser_pop();               // first word out
    check_all("R10 R3");

    // Transmit thresholds (R3, R5)
    while (m_tx < 7) host_tx_push(32'hB000_0000 + m_tx);
    check_all("R3");
    host_tx_push(32'hB000_0007);
    check_all("R3");
    while (m_tx < 15) host_tx_push(32'hB000_0000 + m_tx);
    check_all("R3 R5");
    host_tx_push(32'hB000_000F);
    check_all("R3 R5");
    while (m_tx < DEPTH) host_tx_push(32'hC000_0000 + m_tx);
    check_all("R2");
    host_tx_push(32'hDEAD_BEEF); // full: ignored
    check_all("R12");
    while (m_tx > 0) ser_pop();
    check_all("R2");

    // Transmit underrun (R6, R11)
    int_en = 4'b0100;
    ser_pop();
    check_all("R6 R11");
    int_clear(4'b0100);
    check_all("R6");
    ser_pop();
    check_all("R6");
    ctl_write(CFG | (32'd1 << 15));
    check_all("R6");

    // Receive thresholds and overrun (R4, R5, R7)
    int_en = 4'b0010;
    while (m_rx < 24) ser_push(32'h5000_0000 + m_rx);
    check_all("R4");
    ser_push(32'h5000_0018);
    check_all("R4");
    while (m_rx < 31) ser_push(32'h5000_0000 + m_rx);
    check_all("R5 R11");
    ser_push(32'h5000_001F);
    check_all("R5 R11");
    while (m_rx < 40) ser_push(32'h5000_0000 + m_rx);
    check_all("R4");
    ser_push(32'h5000_0028);
    check_all("R4");
    while (m_rx < DEPTH) ser_push(32'h6000_0000 + m_rx);
    check_all("R2");
    int_en = 4'b1000;
    ser_push(32'h7777_7777);  // dropped
    check_all("R7 R11");
    int_en = 4'b0000;
    while (m_rx > 0) host_rx_pop();
    check_all("R7");
    host_rx_pop();            // empty: ignored
    check_all("R12");
    ctl_write(CFG | (32'd1 << 16));
    check_all("R7");

    // FIFO clear (R8)
    for (int i = 0; i < 5; i++) host_tx_push(32'h8000_0000 + i);
    for (int i = 0; i < 3; i++) ser_push(32'h9000_0000 + i);
    ctl_write(CFG | (32'd1 << 3) | (32'd1 << 4));
    tick();
    check_all("R8");
    tick();
    m_tx = 0; m_rx = 0; txq.delete(); rxq.delete();
    check_all("R8");

    // Sync readback (R9)
    ctl_write(CFG | (32'd1 << 24));
    tick();
    check_all("R9");
    tick(); m_sync = 1;
    check_all("R9");

    // Transmit off (R12)
    ctl_write((CFG & ~32'd4) | (32'd1 << 24));
    host_tx_push(32'h1234_5678);
    ser_pop();
    check_all("R12");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule